// File: doc/BRIEF.md
# Hierarchical Predecoded Row Decoder

This block turns a binary memory address into the select lines of one array access. On each rising clock edge it captures the address. The row field is then split into small groups. Each group feeds a predecoder that produces a one-hot bus of 4, 8 or 16 lines. A second stage ANDs one line from every group bus to form each wordline.

The column and bank fields go through the same predecoder unit. Their outputs are one-hot selects for the column multiplexer and the bank.

A wordline enable input, driven during the access half of the clock, gates only the wordlines. The column and bank selects stay valid for the whole cycle. The row count need not be a power of two. Codes past the last row drive no wordline.

Top module: `rowdec_top`

## Requirements
- R1: The address is captured on the rising edge of `clk` and its fields are decoded from that captured value until the next rising edge. Column index is `addr[COL_BITS-1:0]`, row index is the next `ROW_BITS` bits above it, and bank index is the top `BANK_BITS` bits.
- R2: While `wl_en` is high and the captured row index is below `NUM_ROWS`, exactly one wordline is high: `wordline[row]`.
- R3: While `wl_en` is low, every wordline is low, whatever the captured address.
- R4: A captured row index at or above `NUM_ROWS` drives no wordline, even with `wl_en` high.
- R5: `col_sel` is one-hot with bit `col` set, whatever the value of `wl_en`.
- R6: `bank_sel` is one-hot with bit `bank` set, whatever the value of `wl_en`.
- R7: While `rst_n` is low, the captured address is zero. So `col_sel` and `bank_sel` have bit 0 set, and `wordline[0]` follows `wl_en`.
- R8: The row field is predecoded in 3-bit groups starting at the least significant bit. A final 2-bit group is used when `ROW_BITS mod 3 = 2`. The last group widens to 4 bits when `ROW_BITS mod 3 = 1`. Decoding is correct for every `ROW_BITS` from 4 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the captured address |
| wl_en | input | 1 | Wordline enable for the access phase |
| addr | input | COL_BITS+ROW_BITS+BANK_BITS | Packed address: bank, row, column from MSB to LSB |
| wordline | output | NUM_ROWS | One-hot or all-zero wordline vector |
| col_sel | output | 2**COL_BITS | One-hot column-mux select |
| bank_sel | output | 2**BANK_BITS | One-hot bank select |

## Verification
The bench builds two instances and sweeps every address of each one, with the enable high and again with it low on a stride of addresses.

The default instance has 7 row bits, 100 rows, 2 column bits and 1 bank bit. This gives a 3+4 bit row partition, with the 4-to-16 predecoder on the upper field, and 28 out-of-range row codes (100 to 127).

The second instance has 8 row bits, 200 rows, 1 column bit and 2 bank bits. This gives a 3+3+2 partition, so the 2-to-4 variant and a three-term AND stage are both in use. It adds 56 out-of-range codes and a four-way bank select.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    // Number of row predecode groups for a given row field width.
    function automatic int num_groups(input int w);
        case (w % 3)
            0:       return w / 3;
            1:       return w / 3;       // last 3-bit group widens to 4
            default: return w / 3 + 1;   // extra 2-bit group on top
        endcase
    endfunction

    // Width of predecode group g (groups are numbered from the LSB).
    function automatic int group_width(input int w, input int g);
        if (g != num_groups(w) - 1) return 3;
        case (w % 3)
            0:       return 3;
            1:       return 4;
            default: return 2;
        endcase
    endfunction

    // Lowest row-address bit covered by group g.
    function automatic int group_lsb(input int g);
        return 3 * g;
    endfunction

    // First line of group g on the packed predecode bus (earlier groups are 3-bit).
    function automatic int pd_base(input int g);
        return 8 * g;
    endfunction

    // Total width of the packed row predecode bus.
    function automatic int pd_width(input int w);
        return pd_base(num_groups(w) - 1) + (1 << group_width(w, num_groups(w) - 1));
    endfunction

endpackage

// File: rtl/rowdec_predecode.sv
module rowdec_predecode #(
    parameter int WIDTH = 3
) (
    input  logic [WIDTH-1:0]      sel,
    output logic [(1<<WIDTH)-1:0] lines
);
    localparam int NLINES = 1 << WIDTH;

    // One comparator per output line: 2-to-4, 3-to-8 or 4-to-16 by WIDTH.
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        assign lines[i] = (sel == WIDTH'(i));
    end

endmodule

// File: rtl/rowdec_and_stage.sv
module rowdec_and_stage
    import rowdec_pkg::*;
#(
    parameter int ROW_BITS = 7,
    parameter int NUM_ROWS = 100,
    parameter int PD_W     = 24
) (
    input  logic [PD_W-1:0]     pd_lines,
    input  logic                wl_en,
    output logic [NUM_ROWS-1:0] wordline
);
    localparam int NGROUPS  = num_groups(ROW_BITS);
    localparam int ALL_ROWS = 1 << ROW_BITS;

    logic [ALL_ROWS-1:0] row_hit;

    // Each row code picks one line from every group and ANDs them.
    for (genvar r = 0; r < ALL_ROWS; r++) begin : g_row
        logic [NGROUPS-1:0] terms;
        for (genvar g = 0; g < NGROUPS; g++) begin : g_term
            localparam int GW  = group_width(ROW_BITS, g);
            localparam int IDX = pd_base(g) + ((r >> group_lsb(g)) & ((1 << GW) - 1));
            assign terms[g] = pd_lines[IDX];
        end
        assign row_hit[r] = &terms;
    end

    // Only implemented rows reach the outputs, each gated by the enable (R3, R4).
    assign wordline = row_hit[NUM_ROWS-1:0] & {NUM_ROWS{wl_en}};

    if (NUM_ROWS < ALL_ROWS) begin : g_spare
        logic unused_spare_rows;
        assign unused_spare_rows = ^row_hit[ALL_ROWS-1:NUM_ROWS];
    end

endmodule

// File: rtl/rowdec_top.sv
module rowdec_top
    import rowdec_pkg::*;
#(
    parameter int ROW_BITS  = 7,
    parameter int NUM_ROWS  = 100,
    parameter int COL_BITS  = 2,
    parameter int BANK_BITS = 1
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wl_en,
    input  logic [COL_BITS+ROW_BITS+BANK_BITS-1:0] addr,
    output logic [NUM_ROWS-1:0]                    wordline,
    output logic [(1<<COL_BITS)-1:0]               col_sel,
    output logic [(1<<BANK_BITS)-1:0]              bank_sel
);
    localparam int NGROUPS  = num_groups(ROW_BITS);
    localparam int PD_W     = pd_width(ROW_BITS);
    localparam int ROW_LSB  = COL_BITS;
    localparam int BANK_LSB = COL_BITS + ROW_BITS;

    typedef struct packed {
        logic [BANK_BITS-1:0] bank;
        logic [ROW_BITS-1:0]  row;
        logic [COL_BITS-1:0]  col;
    } fields_t;

    fields_t fields_d, fields_q;

    // R1: field split of the incoming address.
    always_comb begin
        fields_d.col  = addr[COL_BITS-1:0];
        fields_d.row  = addr[ROW_LSB +: ROW_BITS];
        fields_d.bank = addr[BANK_LSB +: BANK_BITS];
    end

    // R7: asynchronous clear of the captured address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fields_q <= '0;
        else        fields_q <= fields_d;
    end

    // R8: row field predecoded group by group.
    logic [PD_W-1:0] row_pd;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_row_grp
        localparam int GW  = group_width(ROW_BITS, g);
        localparam int LSB = group_lsb(g);
        rowdec_predecode #(.WIDTH(GW)) u_row_pd (
            .sel   (fields_q.row[LSB +: GW]),
            .lines (row_pd[pd_base(g) +: (1 << GW)])
        );
    end

    rowdec_and_stage #(
        .ROW_BITS (ROW_BITS),
        .NUM_ROWS (NUM_ROWS),
        .PD_W     (PD_W)
    ) u_and (
        .pd_lines (row_pd),
        .wl_en    (wl_en),
        .wordline (wordline)
    );

    // R5, R6: same predecoder unit, ungated.
    rowdec_predecode #(.WIDTH(COL_BITS)) u_col_pd (
        .sel   (fields_q.col),
        .lines (col_sel)
    );

    rowdec_predecode #(.WIDTH(BANK_BITS)) u_bank_pd (
        .sel   (fields_q.bank),
        .lines (bank_sel)
    );

endmodule

// File: rtl/rowdec_checker.sv
module rowdec_checker #(
    parameter int ROW_BITS  = 7,
    parameter int NUM_ROWS  = 100,
    parameter int COL_BITS  = 2,
    parameter int BANK_BITS = 1
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   wl_en,
    input logic [COL_BITS+ROW_BITS+BANK_BITS-1:0] addr,
    input logic [NUM_ROWS-1:0]                    wordline,
    input logic [(1<<COL_BITS)-1:0]               col_sel,
    input logic [(1<<BANK_BITS)-1:0]              bank_sel
);
    localparam int NC = 1 << COL_BITS;
    localparam int NB = 1 << BANK_BITS;
    localparam logic [NC-1:0]       ONE_C = NC'(1);
    localparam logic [NB-1:0]       ONE_B = NB'(1);
    localparam logic [NUM_ROWS-1:0] ONE_W = NUM_ROWS'(1);

    assert_wl_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wordline));

    assert_row_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && wl_en && (int'($past(addr[COL_BITS +: ROW_BITS])) < NUM_ROWS))
        |-> ((wordline >> $past(addr[COL_BITS +: ROW_BITS])) & ONE_W) == ONE_W);

    assert_wl_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wl_en |-> (wordline == '0));

    assert_row_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (int'($past(addr[COL_BITS +: ROW_BITS])) >= NUM_ROWS))
        |-> (wordline == '0));

    assert_col_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (col_sel == (ONE_C << $past(addr[COL_BITS-1:0]))));

    assert_bank_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bank_sel == (ONE_B << $past(addr[COL_BITS+ROW_BITS +: BANK_BITS]))));

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |-> (col_sel == ONE_C) && (bank_sel == ONE_B));

endmodule

bind rowdec_top rowdec_checker #(
    .ROW_BITS  (ROW_BITS),
    .NUM_ROWS  (NUM_ROWS),
    .COL_BITS  (COL_BITS),
    .BANK_BITS (BANK_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wl_en    (wl_en),
    .addr     (addr),
    .wordline (wordline),
    .col_sel  (col_sel),
    .bank_sel (bank_sel)
);

// File: tb/sim_rowdec_top.sv
module sim_rowdec_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        en0 = 1'b0, en1 = 1'b0;
    logic [9:0]  a0 = '0;
    logic [10:0] a1 = '0;
    logic [99:0]  wl0;
    logic [3:0]   cs0;
    logic [1:0]   bs0;
    logic [199:0] wl1;
    logic [1:0]   cs1;
    logic [3:0]   bs1;

    // Default build: 7 row bits (3+4 groups), 100 rows, 4 columns, 2 banks.
    rowdec_top u0 (
        .clk(clk), .rst_n(rst_n), .wl_en(en0), .addr(a0),
        .wordline(wl0), .col_sel(cs0), .bank_sel(bs0)
    );

    // R8: 8 row bits (3+3+2 groups), 200 rows, 2 columns, 4 banks.
    rowdec_top #(.ROW_BITS(8), .NUM_ROWS(200), .COL_BITS(1), .BANK_BITS(2)) u1 (
        .clk(clk), .rst_n(rst_n), .wl_en(en1), .addr(a1),
        .wordline(wl1), .col_sel(cs1), .bank_sel(bs1)
    );

    typedef struct {
        int unit;
        int row;
        int col;
        int bank;
        bit en;
    } exp_t;

    exp_t sb_q[$];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic void compare(exp_t e);
        logic [255:0] exp_wl, act_wl;
        logic [15:0]  exp_c, act_c, exp_b, act_b;
        int nr;
        string tag;
        nr     = (e.unit == 0) ? 100 : 200;
        act_wl = (e.unit == 0) ? 256'(wl0) : 256'(wl1);
        act_c  = (e.unit == 0) ? 16'(cs0) : 16'(cs1);
        act_b  = (e.unit == 0) ? 16'(bs0) : 16'(bs1);
        exp_wl = '0;
        if (e.en && e.row < nr) exp_wl[e.row] = 1'b1;
        exp_c = 16'(1) << e.col;
        exp_b = 16'(1) << e.bank;
        n_checks++;
        if (act_wl !== exp_wl) begin
            n_fail++;
            tag = !e.en ? "R3" : ((e.row >= nr) ? "R4" : "R2");
            if (e.unit == 1) tag = {tag, " R8"};
            $display("FAIL %s unit %0d row %0d en %0b: wordline got %h expected %h",
                     tag, e.unit, e.row, e.en, act_wl, exp_wl);
        end else if (act_c !== exp_c) begin
            n_fail++;
            $display("FAIL R5 unit %0d col %0d: col_sel got %h expected %h",
                     e.unit, e.col, act_c, exp_c);
        end else if (act_b !== exp_b) begin
            n_fail++;
            $display("FAIL R6 unit %0d bank %0d: bank_sel got %h expected %h",
                     e.unit, e.bank, act_b, exp_b);
        end
    endfunction

    // R1: fields taken as col at LSB, row above it, bank at the top; result
    // expected after the next rising edge.
    task automatic drive0(input int a, input bit en);
        @(negedge clk);
        a0  = 10'(a);
        en0 = en;
        #1 sb_q.push_back('{0, (a >> 2) & 127, a & 3, (a >> 9) & 1, en});
    endtask

    task automatic drive1(input int a, input bit en);
        @(negedge clk);
        a1  = 11'(a);
        en1 = en;
        #1 sb_q.push_back('{1, (a >> 1) & 255, a & 1, (a >> 9) & 3, en});
    endtask

    // Monitor: outputs settle after the capturing edge; compare 3 ns later.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb_q.size() > 0) compare(sb_q.pop_front());
        end
    end

    // Watchdog
    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R7: reset state, enable high, address nonzero at the pins.
        a0  = 10'h3ff;
        a1  = 11'h7ff;
        en0 = 1'b1;
        en1 = 1'b1;
        #12;
        n_checks++;
        if (wl0 !== 100'(1) || cs0 !== 4'b0001 || bs0 !== 2'b01) begin
            n_fail++;
            $display("FAIL R7 unit 0 reset: wl %h cs %b bs %b expected wl 1 cs 0001 bs 01",
                     wl0, cs0, bs0);
        end
        n_checks++;
        if (wl1 !== 200'(1) || cs1 !== 2'b01 || bs1 !== 4'b0001) begin
            n_fail++;
            $display("FAIL R7 unit 1 reset: wl %h cs %b bs %b expected wl 1 cs 01 bs 0001",
                     wl1, cs1, bs1);
        end
        en0 = 1'b0;
        #1;
        n_checks++;
        if (wl0 !== '0) begin
            n_fail++;
            $display("FAIL R7 unit 0 reset enable low: wl %h expected 0", wl0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Unit 0: full sweep enabled (R2, R4, R5, R6), then a stride disabled (R3).
        for (int a = 0; a < 1024; a++) drive0(a, 1'b1);
        for (int a = 0; a < 1024; a += 37) drive0(a, 1'b0);
        // Same address, enable toggling back and forth.
        for (int k = 0; k < 6; k++) drive0(10'h1a5, k[0]);

        // Unit 1: R8 partition, full sweep enabled then a stride disabled.
        for (int a = 0; a < 2048; a++) drive1(a, 1'b1);
        for (int a = 0; a < 2048; a += 53) drive1(a, 1'b0);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule